// File: doc/BRIEF.md
# USB 2.0 Host Command Register with Interrupt Moderation

This block holds the command word of a USB 2.0 host controller and the logic that sets the interrupt rate from it. Software reads and writes the word over a small register bus. The word carries the two schedule-enable bits, which the block drives out to the schedule walkers. It also carries a self-clearing doorbell bit that asks the controller to announce the next advance of the asynchronous schedule. Last, it carries a one-hot threshold field that sets how many micro-frames pass between interrupts.

A second bus address reaches a small write-1-to-clear status word. Bit 0 of that word is the async-advance cause, which the block sets itself when the controller reports that its cached asynchronous state has been evicted. The other bits take event pulses from neighbouring logic. A moderation counter advances on each micro-frame tick. The interrupt line is raised only on a threshold boundary, and only while some enabled status bit is pending.

Top module: `uhc_cmd_irq_mod`

## Requirements
- R1: Address 0 reads the command word with periodic enable at bit 4, async enable at bit 5, doorbell at bit 6 and the threshold at bits 23:16. Writes load bits 4 and 5, and the outputs `per_sched_en` and `async_sched_en` follow them.
- R2: While `rst_n` is low, and after it is released, the command word reads 00080000h, the status word reads 0, and `irq` and `doorbell` are 0.
- R3: A cycle with `hc_rst` high returns the command word to 00080000h, clears the status word and restarts the moderation counter from zero.
- R4: Writing 1 to bit 6 sets the doorbell, and writing 0 does not clear it. On the edge where `evict_done` is high while the doorbell is set, the doorbell clears and status bit 0 sets.
- R5: Bits 31:24, 15:7 and 3:0 of the command word always read 0, whatever is written to them.
- R6: A threshold write whose value is not one of 01h, 02h, 04h, 08h, 10h, 20h or 40h leaves the previous threshold in place.
- R7: The counter counts `uframe_tick` pulses. On the tick that brings the count since the last boundary or restart to the threshold N, a boundary occurs and the count restarts. `irq` rises only after a boundary edge at which an enabled status bit was pending, and it stays 0 while no enabled status bit is pending.
- R8: Address 1 reads the status word in bits 3:0. Writing 1 to a status bit clears it. When the write leaves no status bit pending, `irq` is 0 in the cycle after the write.
- R9: `evict_done` while the doorbell is clear has no effect on the status word or the command word.
- R10: Bit k of `ext_evt` sets status bit k+1. A set and a write-1-to-clear of the same bit in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hc_rst | input | 1 | Synchronous controller reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command word, 1 = status word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| uframe_tick | input | 1 | One pulse per micro-frame |
| evict_done | input | 1 | Cached asynchronous state has been evicted |
| ext_evt | input | 3 | Event pulses for status bits 3:1 |
| cause_en | input | 4 | Per-cause interrupt enables |
| irq | output | 1 | Moderated interrupt line |
| per_sched_en | output | 1 | Periodic schedule enable |
| async_sched_en | output | 1 | Asynchronous schedule enable |
| doorbell | output | 1 | Async-advance doorbell state |

## Verification
The bench pulses ticks up to the boundary and checks that `irq` stays low one tick short of it. A counter off by one would raise the line a tick early or late. It writes 0 to a rung doorbell, sends an eviction with no doorbell rung, and writes threshold codes of 00h, 03h, 05h and 80h. A design that let software clear the doorbell, or that loaded an illegal code, would read back a changed word. It also sets and clears the same status bit in one cycle, and removes the cause enables while the line is high. Getting these wrong would lose an event or leave `irq` stuck high.

// File: rtl/uhc_cmd_pkg.sv
package uhc_cmd_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned THR_LSB      = 16;
  localparam int unsigned THR_W        = 8;
  localparam int unsigned BIT_PER_EN   = 4;
  localparam int unsigned BIT_ASYNC_EN = 5;
  localparam int unsigned BIT_DOORBELL = 6;
  localparam int unsigned MAX_UFRAMES  = 64;
  localparam int unsigned CNT_W        = THR_W;
  localparam logic [THR_W-1:0] THR_RESET = 8'h08;

  typedef enum logic {ADDR_CMD = 1'b0, ADDR_STS = 1'b1} reg_addr_e;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic             async_en;
    logic             per_en;
    logic             doorbell;
  } cmd_t;

  localparam cmd_t CMD_RESET = '{thr: THR_RESET, async_en: 1'b0, per_en: 1'b0, doorbell: 1'b0};

  function automatic logic thr_is_legal(input logic [THR_W-1:0] v);
    return ($countones(v) == 1) && (v <= THR_W'(MAX_UFRAMES));
  endfunction
endpackage

// File: rtl/uhc_rst_sync.sv
module uhc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/uhc_cmd_regs.sv
module uhc_cmd_regs
  import uhc_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hc_rst,
  input  logic             wr_cmd,
  input  logic [REG_W-1:0] wdata,
  input  logic             evict_done,
  output cmd_t             cmd_q,
  output logic             evict_ack
);
  cmd_t             cmd_d;
  logic             cmd_en;
  logic [THR_W-1:0] wr_thr;

  assign wr_thr    = wdata[THR_LSB +: THR_W];
  assign evict_ack = cmd_q.doorbell & evict_done;
  assign cmd_en    = wr_cmd | evict_ack | hc_rst;

  always_comb begin
    cmd_d = cmd_q;
    if (wr_cmd) begin
      cmd_d.per_en   = wdata[BIT_PER_EN];
      cmd_d.async_en = wdata[BIT_ASYNC_EN];
      if (wdata[BIT_DOORBELL]) cmd_d.doorbell = 1'b1;
      if (thr_is_legal(wr_thr)) cmd_d.thr = wr_thr;
    end
    if (evict_ack) cmd_d.doorbell = 1'b0;
    if (hc_rst)    cmd_d = CMD_RESET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= CMD_RESET;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  AST_THR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd && !thr_is_legal(wr_thr) && !hc_rst |=> $stable(cmd_q.thr)); // R6
  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.doorbell && !evict_done && !hc_rst |=> cmd_q.doorbell); // R4
endmodule

// File: rtl/uhc_sts_regs.sv
module uhc_sts_regs #(
  parameter int unsigned NCAUSE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hc_rst,
  input  logic              wr_sts,
  input  logic [NCAUSE-1:0] wclr,
  input  logic [NCAUSE-1:0] set_vec,
  output logic [NCAUSE-1:0] sts_q
);
  logic [NCAUSE-1:0] sts_d;
  logic [NCAUSE-1:0] clr_mask;
  logic              sts_en;

  assign clr_mask = wr_sts ? wclr : '0;
  assign sts_en   = wr_sts | (|set_vec) | hc_rst;

  always_comb begin
    sts_d = (sts_q & ~clr_mask) | set_vec;
    if (hc_rst) sts_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !hc_rst && (|set_vec) |=> ((sts_q & $past(set_vec)) == $past(set_vec))); // R10
endmodule

// File: rtl/uhc_irq_mod.sv
module uhc_irq_mod
  import uhc_cmd_pkg::*;
#(
  parameter int unsigned NCAUSE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hc_rst,
  input  logic              tick,
  input  logic [THR_W-1:0]  thr,
  input  logic [NCAUSE-1:0] sts,
  input  logic [NCAUSE-1:0] en,
  output logic              irq
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             armed_q, armed_d;
  logic             pending, boundary, cnt_en;

  assign pending  = |(sts & en);
  assign cnt_inc  = cnt_q + 1'b1;
  assign boundary = tick && (cnt_inc >= thr);
  assign cnt_en   = tick | hc_rst;

  always_comb begin
    cnt_d = boundary ? '0 : cnt_inc;
    if (hc_rst) cnt_d = '0;
  end

  always_comb begin
    armed_d = pending & (armed_q | boundary);
    if (hc_rst) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign irq = armed_q & pending;

  AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick)); // R7
endmodule

// File: rtl/uhc_cmd_irq_mod.sv
module uhc_cmd_irq_mod
  import uhc_cmd_pkg::*;
#(
  parameter int unsigned NCAUSE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hc_rst,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              uframe_tick,
  input  logic              evict_done,
  input  logic [NCAUSE-2:0] ext_evt,
  input  logic [NCAUSE-1:0] cause_en,
  output logic              irq,
  output logic              per_sched_en,
  output logic              async_sched_en,
  output logic              doorbell
);
  logic              rst_sync_n;
  logic              wr_cmd, wr_sts, evict_ack;
  cmd_t              cmd_q;
  logic [NCAUSE-1:0] sts_q;
  logic [REG_W-1:0]  cmd_img, sts_img;

  uhc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .rst_n_sync(rst_sync_n)
  );

  assign wr_cmd = bus_wr && (reg_addr_e'(bus_addr) == ADDR_CMD);
  assign wr_sts = bus_wr && (reg_addr_e'(bus_addr) == ADDR_STS);

  uhc_cmd_regs u_cmd (
    .clk(clk), .rst_n(rst_sync_n), .hc_rst(hc_rst), .wr_cmd(wr_cmd),
    .wdata(bus_wdata), .evict_done(evict_done), .cmd_q(cmd_q), .evict_ack(evict_ack)
  );

  uhc_sts_regs #(.NCAUSE(NCAUSE)) u_sts (
    .clk(clk), .rst_n(rst_sync_n), .hc_rst(hc_rst), .wr_sts(wr_sts),
    .wclr(bus_wdata[NCAUSE-1:0]), .set_vec({ext_evt, evict_ack}), .sts_q(sts_q)
  );

  uhc_irq_mod #(.NCAUSE(NCAUSE)) u_mod (
    .clk(clk), .rst_n(rst_sync_n), .hc_rst(hc_rst), .tick(uframe_tick),
    .thr(cmd_q.thr), .sts(sts_q), .en(cause_en), .irq(irq)
  );

  always_comb begin
    cmd_img                        = '0;
    cmd_img[THR_LSB +: THR_W]      = cmd_q.thr;
    cmd_img[BIT_DOORBELL]          = cmd_q.doorbell;
    cmd_img[BIT_ASYNC_EN]          = cmd_q.async_en;
    cmd_img[BIT_PER_EN]            = cmd_q.per_en;
    sts_img                        = '0;
    sts_img[NCAUSE-1:0]            = sts_q;
  end

  assign bus_rdata      = (reg_addr_e'(bus_addr) == ADDR_STS) ? sts_img : cmd_img;
  assign per_sched_en   = cmd_q.per_en;
  assign async_sched_en = cmd_q.async_en;
  assign doorbell       = cmd_q.doorbell;

  AST_DB_EVICT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_q.doorbell && evict_done && !hc_rst |=> !cmd_q.doorbell && sts_q[0]); // R4
  AST_EVICT_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cmd_q.doorbell && evict_done |=> !$rose(sts_q[0])); // R9
  AST_W1C_DROP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_sts && ((sts_q & ~bus_wdata[NCAUSE-1:0]) == '0) && (ext_evt == '0) && !evict_ack
      |=> !irq); // R8
endmodule

// File: tb/uhc_cmd_irq_mod_bench.sv
module uhc_cmd_irq_mod_bench;
  logic        clk = 1'b0;
  logic        rst_n, hc_rst, bus_wr, bus_addr, uframe_tick, evict_done;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  ext_evt;
  logic [3:0]  cause_en;
  logic        irq, per_sched_en, async_sched_en, doorbell;
  int          n_checks = 0;
  int          n_errors = 0;

  always #4 clk = ~clk;

  uhc_cmd_irq_mod u_uhc_cmd_irq_mod (
    .clk(clk), .rst_n(rst_n), .hc_rst(hc_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uframe_tick(uframe_tick),
    .evict_done(evict_done), .ext_evt(ext_evt), .cause_en(cause_en), .irq(irq),
    .per_sched_en(per_sched_en), .async_sched_en(async_sched_en), .doorbell(doorbell)
  );

  // {write data to address 0, expected read of address 0}
  localparam logic [63:0] VEC [9] = '{
    {32'h0000_0010, 32'h0008_0010},  // R1 periodic enable
    {32'h0000_0020, 32'h0008_0020},  // R1 async enable
    {32'h0001_0000, 32'h0001_0000},  // R1 threshold 1
    {32'h0040_0000, 32'h0040_0000},  // R1 threshold 64
    {32'h0000_0000, 32'h0040_0000},  // R6 00h kept out
    {32'h0003_0000, 32'h0040_0000},  // R6 two bits set
    {32'h0080_0000, 32'h0040_0000},  // R6 80h out of range
    {32'h0020_0F8F, 32'h0020_0000},  // R5 read-only and reserved bits
    {32'hFF08_F030, 32'h0008_0030}   // R5 upper reserved byte
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      uframe_tick = 1'b1; @(posedge clk); #1; uframe_tick = 1'b0;
    end
  endtask

  task automatic pulse_evict();
    evict_done = 1'b1; @(posedge clk); #1; evict_done = 1'b0;
  endtask

  task automatic pulse_ext(input logic [2:0] m);
    ext_evt = m; @(posedge clk); #1; ext_evt = '0;
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; hc_rst = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    uframe_tick = 1'b0; evict_done = 1'b0; ext_evt = '0; cause_en = '0;
    #10;
    rd(1'b0, r); check("R2 cmd in reset", r, 32'h0008_0000);
    #10 rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    rd(1'b0, r); check("R2 cmd after reset", r, 32'h0008_0000);
    rd(1'b1, r); check("R2 status after reset", r, 32'h0);
    check("R2 irq and doorbell", {30'h0, irq, doorbell}, 32'h0);

    for (int i = 0; i < 9; i++) begin
      wr(1'b0, VEC[i][63:32]);
      rd(1'b0, r);
      check($sformatf("R1/R5/R6 vector %0d", i), r, VEC[i][31:0]);
    end
    check("R1 schedule enable outputs", {30'h0, async_sched_en, per_sched_en}, 32'h3);

    hc_rst = 1'b1; @(posedge clk); #1; hc_rst = 1'b0;
    rd(1'b0, r); check("R3 controller reset", r, 32'h0008_0000);
    check("R3 outputs cleared", {30'h0, async_sched_en, per_sched_en}, 32'h0);

    cause_en = 4'hF;
    pulse_ext(3'b001);
    rd(1'b1, r); check("R10 event sets status bit 1", r, 32'h2);
    ticks(7);
    check("R7 no irq before boundary", {31'h0, irq}, 32'h0);
    ticks(1);
    check("R7 irq at 8th tick", {31'h0, irq}, 32'h1);
    wr(1'b1, 32'h2);
    check("R8 irq drops after clear", {31'h0, irq}, 32'h0);
    rd(1'b1, r); check("R8 status cleared", r, 32'h0);

    wr(1'b0, 32'h0000_0040);
    rd(1'b0, r); check("R4 doorbell rung", r, 32'h0008_0040);
    wr(1'b0, 32'h0000_0000);
    rd(1'b0, r); check("R4 write 0 keeps doorbell", r, 32'h0008_0040);
    pulse_evict();
    rd(1'b0, r); check("R4 doorbell self-clears", r, 32'h0008_0000);
    rd(1'b1, r); check("R4 async status set", r, 32'h1);
    check("R7 irq held until boundary", {31'h0, irq}, 32'h0);
    ticks(8);
    check("R7 async cause irq at boundary", {31'h0, irq}, 32'h1);

    ext_evt = 3'b010;
    wr(1'b1, 32'h5);
    ext_evt = '0;
    rd(1'b1, r); check("R10 set wins over clear", r, 32'h4);
    cause_en = 4'h0; #1;
    check("R7 irq low with causes disabled", {31'h0, irq}, 32'h0);
    ticks(8);
    check("R7 disabled cause at boundary", {31'h0, irq}, 32'h0);
    cause_en = 4'hF; #1;
    check("R7 re-enable waits for boundary", {31'h0, irq}, 32'h0);
    wr(1'b1, 32'hF);

    pulse_evict();
    rd(1'b1, r); check("R9 eviction ignored status", r, 32'h0);
    rd(1'b0, r); check("R9 eviction ignored cmd", r, 32'h0008_0000);

    wr(1'b0, 32'h0002_0000);
    pulse_ext(3'b100);
    ticks(1);
    check("R7 thr 2 first tick", {31'h0, irq}, 32'h0);
    ticks(1);
    check("R7 thr 2 second tick", {31'h0, irq}, 32'h1);
    wr(1'b0, 32'h0005_0000);
    rd(1'b0, r); check("R6 illegal keeps 02h", r, 32'h0002_0000);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule